// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This unit walks a vector one element per cycle under a per-element mask and produces a stream of element writes for a destination vector register. In pack mode (compress), the elements whose mask bit is set are written one after another into destination positions 0, 1, 2 and so on, in the order they appear in the source. In unpack mode (expand), the destination positions whose mask bit is set receive the source elements in order: the first such position gets source element 0, the next gets source element 1, and so on. Destination positions whose mask bit is clear are never written.

The surrounding register file is outside the block. The unit presents the position it is scanning (`scan_idx`) and the source element it wants (`src_idx`), and expects the mask bit and source element for those indices back in the same cycle. Results leave through a registered write port (`wr_en`, `wr_idx`, `wr_data`). When the scan finishes, `done` pulses for one cycle and `pop_cnt` holds the number of set mask bits among the examined elements, which is the length of the packed vector.

Top module: `vmce_unit`

## Requirements
- R1: In pack mode (`mode`=0), for each examined position i with mask bit 1, the unit writes source element i to destination position k, where k counts the set bits below i; positions keep their source order and start at 0.
- R2: When `done` is high, `pop_cnt` equals the number of set mask bits among the examined positions; it keeps that value until the next `done`, and it is 0 after reset.
- R3: In unpack mode (`mode`=1), the k-th set mask bit (counting from 0) at position i causes source element k to be written to destination position i.
- R4: No write is issued for a position whose mask bit is clear, in either mode, and every write index is below the effective vector length.
- R5: Only the first VL mask bits are examined, where VL is `vlen` captured at start, clamped to 64 when larger; mask bits at or above VL have no effect. VL=0 produces no writes, `pop_cnt`=0 and a `done` pulse.
- R6: One position is handled per cycle: with start sampled at clock edge E, `busy` is high from E until `done`, and `done` is high after edge E+VL for VL>0 (after E itself for VL=0); the last write and `done` appear together.
- R7: `mode` and `vlen` are captured at the start edge; changing them, or raising `start`, while `busy` is high has no effect on the running operation.
- R8: After synchronous reset, `busy`, `done` and `wr_en` are 0 and `pop_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when the unit is idle |
| mode | input | 1 | 0 = pack (compress), 1 = unpack (expand); sampled at start |
| vlen | input | 7 | Vector length, sampled at start; values above 64 act as 64 |
| mask_bit | input | 1 | Mask bit of position `scan_idx`, same cycle |
| src_data | input | 32 | Source element at index `src_idx`, same cycle |
| busy | output | 1 | Operation in progress |
| scan_idx | output | 6 | Position currently examined |
| src_idx | output | 6 | Source element requested this cycle |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 6 | Destination position of the write |
| wr_data | output | 32 | Element written |
| done | output | 1 | One-cycle pulse at the end of an operation |
| pop_cnt | output | 7 | Set mask bits among the examined positions |

## Verification
The hardest situation to reach is a run in which the inputs change under a busy unit: a flipped mode, a new length and a second start pulse arriving mid-scan must all leave the result untouched. The bench drives exactly that sequence during a long pack operation and compares the whole destination image against a model computed for the original settings. A second hard case is mask bits set beyond the vector length, including a length above 64 that must clamp; vectors with only high mask bits set and an oversized length reach both, and the destination image shows whether any of those bits leaked through.

// File: rtl/vmce_pkg.sv
package vmce_pkg;

    // Operation selected at start
    typedef enum logic {
        MODE_PACK   = 1'b0,
        MODE_UNPACK = 1'b1
    } vmce_mode_e;

    // Per-cycle scan step handed from the sequencer to the write stage
    typedef struct packed {
        logic live;    // a position is being examined this cycle
        logic active;  // its mask bit is set
        logic last;    // it is the final position of the vector
    } vmce_step_t;

    function automatic logic is_unpack(input vmce_mode_e m);
        return m == MODE_UNPACK;
    endfunction

endpackage

// File: rtl/vmce_scan_ctrl.sv
module vmce_scan_ctrl
    import vmce_pkg::*;
#(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_in,
    input  logic [LEN_W-1:0] vlen,
    input  logic             mask_bit,
    output logic             launch,
    output logic             launch_empty,
    output vmce_mode_e       mode_q,
    output logic [IDX_W-1:0] pos,
    output vmce_step_t       step
);

    logic             busy_q;
    logic [LEN_W-1:0] vl_q;
    logic [LEN_W-1:0] vl_eff;

    assign vl_eff       = (vlen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vlen;
    assign launch       = start && !busy_q;
    assign launch_empty = launch && (vl_eff == '0);

    assign step.live   = busy_q;
    assign step.active = busy_q && mask_bit;
    assign step.last   = busy_q && (LEN_W'(pos) == vl_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            vl_q   <= '0;
            pos    <= '0;
            mode_q <= MODE_PACK;
        end else if (launch) begin
            mode_q <= vmce_mode_e'(mode_in);
            pos    <= '0;
            vl_q   <= vl_eff;
            busy_q <= (vl_eff != '0);
        end else if (busy_q) begin
            if (step.last) begin
                busy_q <= 1'b0;
            end else begin
                pos <= pos + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/vmce_pack_count.sv
module vmce_pack_count #(
    parameter int MAX_VL = 64,
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [LEN_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (advance) begin
            count <= count + LEN_W'(1);
        end
    end

endmodule

// File: rtl/vmce_write_stage.sv
module vmce_write_stage
    import vmce_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  vmce_mode_e        mode_q,
    input  vmce_step_t        step,
    input  logic              launch_empty,
    input  logic [IDX_W-1:0]  pos,
    input  logic [LEN_W-1:0]  count,
    input  logic [ELEM_W-1:0] src_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ELEM_W-1:0] wr_data,
    output logic              done,
    output logic [LEN_W-1:0]  pop_cnt
);

    logic [IDX_W-1:0] dest_sel;

    // Unpack writes at the scanned position, pack at the running count
    assign dest_sel = is_unpack(mode_q) ? pos : count[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            done    <= 1'b0;
            pop_cnt <= '0;
        end else begin
            wr_en <= step.active;
            done  <= step.last || launch_empty;
            if (step.active) begin
                wr_idx  <= dest_sel;
                wr_data <= src_data;
            end
            if (step.last) begin
                pop_cnt <= count + LEN_W'(step.active);
            end else if (launch_empty) begin
                pop_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/vmce_unit.sv
module vmce_unit
    import vmce_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [LEN_W-1:0]  vlen,
    input  logic              mask_bit,
    input  logic [ELEM_W-1:0] src_data,
    output logic              busy,
    output logic [IDX_W-1:0]  scan_idx,
    output logic [IDX_W-1:0]  src_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ELEM_W-1:0] wr_data,
    output logic              done,
    output logic [LEN_W-1:0]  pop_cnt
);

    logic             launch;
    logic             launch_empty;
    vmce_mode_e       mode_q;
    logic [IDX_W-1:0] pos;
    vmce_step_t       step;
    logic [LEN_W-1:0] count;

    vmce_scan_ctrl #(.MAX_VL(MAX_VL)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode_in      (mode),
        .vlen         (vlen),
        .mask_bit     (mask_bit),
        .launch       (launch),
        .launch_empty (launch_empty),
        .mode_q       (mode_q),
        .pos          (pos),
        .step         (step)
    );

    vmce_pack_count #(.MAX_VL(MAX_VL)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (launch),
        .advance (step.active),
        .count   (count)
    );

    vmce_write_stage #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL)) wr_i (
        .clk          (clk),
        .rst          (rst),
        .mode_q       (mode_q),
        .step         (step),
        .launch_empty (launch_empty),
        .pos          (pos),
        .count        (count),
        .src_data     (src_data),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .done         (done),
        .pop_cnt      (pop_cnt)
    );

    assign busy     = step.live;
    assign scan_idx = pos;
    // Pack reads the element under scan; unpack reads the next unconsumed one
    assign src_idx  = is_unpack(mode_q) ? count[IDX_W-1:0] : pos;

endmodule

// File: rtl/vmce_unit_chk.sv
module vmce_unit_chk #(
    parameter int MAX_VL = 64,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             mode,
    input logic [LEN_W-1:0] vlen,
    input logic             busy,
    input logic             done,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [LEN_W-1:0] pop_cnt
);

    logic             launched;
    logic             mode_l;
    logic [LEN_W-1:0] vl_l;
    logic [LEN_W-1:0] wcnt;
    logic [IDX_W-1:0] prev_idx;
    logic             seen;

    assign launched = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_l   <= 1'b0;
            vl_l     <= '0;
            wcnt     <= '0;
            prev_idx <= '0;
            seen     <= 1'b0;
        end else if (launched) begin
            mode_l <= mode;
            vl_l   <= (vlen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vlen;
            wcnt   <= '0;
            seen   <= 1'b0;
        end else if (wr_en) begin
            wcnt     <= wcnt + LEN_W'(1);
            prev_idx <= wr_idx;
            seen     <= 1'b1;
        end
    end

    // R4
    wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (LEN_W'(wr_idx) < vl_l));

    // R1
    pack_dense_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mode_l) |-> (LEN_W'(wr_idx) == wcnt));

    // R3
    unpack_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode_l && seen) |-> (wr_idx > prev_idx));

    // R2
    pop_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pop_cnt == wcnt + LEN_W'(wr_en)));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    write_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(busy));

endmodule

bind vmce_unit vmce_unit_chk #(.MAX_VL(MAX_VL)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mode    (mode),
    .vlen    (vlen),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .pop_cnt (pop_cnt)
);

// File: tb/vmce_unit_tb.sv
`timescale 1ns/1ps
module vmce_unit_tb_top;

    localparam int EW = 32;
    localparam int NV = 64;

    typedef struct packed {
        logic        m;
        logic [6:0]  vl;
        logic [63:0] mk;
        logic [31:0] seed;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 7'd16, 64'h0000_0000_0000_A5C3, 32'h1000_0000},
        '{1'b1, 7'd16, 64'h0000_0000_0000_A5C3, 32'h2000_0000},
        '{1'b0, 7'd64, 64'hFFFF_FFFF_FFFF_FFFF, 32'h3000_0000},
        '{1'b1, 7'd64, 64'h8000_0000_0000_0001, 32'h4000_0000},
        '{1'b0, 7'd10, 64'hFFFF_FFFF_FFFF_F000, 32'h5000_0000},
        '{1'b1, 7'd7,  64'hFFFF_FFFF_FFFF_FF55, 32'h6000_0000},
        '{1'b0, 7'd1,  64'h0000_0000_0000_0001, 32'h7000_0000},
        '{1'b1, 7'd33, 64'h0000_0001_2345_6789, 32'h8000_0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [6:0]    vlen = '0;
    logic          mask_bit;
    logic [EW-1:0] src_data;
    logic          busy;
    logic [5:0]    scan_idx;
    logic [5:0]    src_idx;
    logic          wr_en;
    logic [5:0]    wr_idx;
    logic [EW-1:0] wr_data;
    logic          done;
    logic [6:0]    pop_cnt;

    logic [EW-1:0] src_mem [NV];
    logic [63:0]   mask_q = '0;
    logic [EW-1:0] dst [NV];
    logic [EW-1:0] exp_dst [NV];

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign mask_bit = mask_q[scan_idx];
    assign src_data = src_mem[src_idx];

    vmce_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .vlen(vlen),
        .mask_bit(mask_bit), .src_data(src_data), .busy(busy),
        .scan_idx(scan_idx), .src_idx(src_idx), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .done(done), .pop_cnt(pop_cnt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one operation; disturb flips mode/vlen and pulses start mid-run
    task automatic run_op(input logic m, input int vl, input logic [63:0] mk,
                          input logic [31:0] seed, input bit disturb,
                          input string tag);
        int vle;
        int k;
        int cyc;
        int nwr;
        int bad;
        int first_bad;
        bit busy_ok;
        vle = (vl > NV) ? NV : vl;
        for (int i = 0; i < NV; i++) begin
            src_mem[i] = seed + 32'(i) * 32'h0001_0203 + 32'h11;
            dst[i]     = 32'hBAD0_0000 | 32'(i);
            exp_dst[i] = 32'hBAD0_0000 | 32'(i);
        end
        mask_q = mk;
        k = 0;
        for (int i = 0; i < vle; i++) begin
            if (mk[i]) begin
                if (!m) exp_dst[k] = src_mem[i];
                else    exp_dst[i] = src_mem[k];
                k++;
            end
        end
        @(negedge clk);
        start = 1'b1; mode = m; vlen = 7'(vl);
        @(negedge clk);
        start = 1'b0;
        cyc = 1; nwr = 0;
        busy_ok = (vle == 0) ? !busy : busy;
        if (disturb) begin mode = ~m; vlen = 7'd3; end
        while (1) begin
            if (wr_en) begin dst[wr_idx] = wr_data; nwr++; end
            if (done || cyc > 200) break;
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 3) start = 1'b1;
            if (disturb && cyc == 4) start = 1'b0;
        end
        bad = 0; first_bad = -1;
        for (int i = 0; i < NV; i++)
            if (dst[i] !== exp_dst[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        if (first_bad < 0) first_bad = 0;
        check(bad == 0, m ? "R3/R4" : "R1/R4", {tag, " dest image"},
              dst[first_bad], exp_dst[first_bad]);
        check(pop_cnt == 7'(k), "R2", {tag, " pop_cnt"}, pop_cnt, k);
        check(nwr == k, "R4", {tag, " write count"}, nwr, k);
        check(cyc == ((vle == 0) ? 1 : vle + 1), "R6", {tag, " done latency"},
              cyc, (vle == 0) ? 1 : vle + 1);
        check(busy_ok, "R6", {tag, " busy after start"}, busy, vle != 0);
        @(negedge clk);
        check(!done && !busy && pop_cnt == 7'(k), "R2", {tag, " idle hold"},
              {done, busy, pop_cnt}, {2'b00, 7'(k)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!busy && !done && !wr_en && pop_cnt == 0, "R8", "reset state",
              {busy, done, wr_en, pop_cnt}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !wr_en && pop_cnt == 0, "R8", "after reset",
              {busy, done, wr_en, pop_cnt}, 0);

        // Table of vectors (R1, R3, R5 via high-only mask in entry 4)
        for (int v = 0; v < NVEC; v++)
            run_op(VECS[v].m, int'(VECS[v].vl), VECS[v].mk, VECS[v].seed, 1'b0,
                   $sformatf("vec%0d", v));

        // R5: zero length in both modes
        run_op(1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hA000_0000, 1'b0, "R5 vl0 pack");
        run_op(1'b1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hA100_0000, 1'b0, "R5 vl0 unpack");
        // R5: oversize length clamps to 64
        run_op(1'b1, 100, 64'hF0F0_0F0F_3C3C_C3C3, 32'hB000_0000, 1'b0, "R5 clamp");
        run_op(1'b0, 127, 64'h8000_0000_0000_0000, 32'hB100_0000, 1'b0, "R5 clamp top");
        // R4: empty mask at full length
        run_op(1'b1, 64, 64'h0, 32'hC000_0000, 1'b0, "R4 empty mask");
        // R7: inputs disturbed while busy
        run_op(1'b0, 20, 64'h0000_0000_000A_AA5F, 32'hD000_0000, 1'b1, "R7 pack disturb");
        run_op(1'b1, 24, 64'h0000_0000_00C3_0F81, 32'hD100_0000, 1'b1, "R7 unpack disturb");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule